// File: doc/BRIEF.md
# SRAM Bus Cycle Timing Sequencer

This block runs one access to an external asynchronous memory at a time. It drives an active-low chip select and separate active-low read and write strobes, and it presents the address and write data on the bus. Software sets the timing in a small register: a setup count, an address-hold count, a wait count and a strobe-hold count. A request carries an address, write data, a direction and an interface type. The block samples the timing values when it accepts a request and keeps them for the whole access.

An access moves through these phases in order:
- Chip select falls and is held for one cycle with both strobes inactive.
- Setup cycles follow, still with both strobes inactive.
- The strobe is active for one base cycle plus the wait cycles.
- Strobe-hold cycles follow, with chip select still low.
- Address-hold cycles follow, with chip select still low.
- One final cycle raises chip select and pulses `done`.

On a read, the block captures the memory data at the end of the last strobe cycle and returns it on `rsp_rdata`. Setup and address hold apply only to the three memory-style interface types. For the remaining type, both fields are ignored.

Top module: `sram_seq`

## Requirements
- R1: While `rst_n` is low, `cs_n`, `rd_n` and `we_n` are all 1. After reset is released, `req_ready` is 1.
- R2: Reset sets the setup and address-hold fields to 7 and the wait and strobe-hold fields to 0. A request made before any `cfg_we` write uses these values.
- R3: The interface type is encoded as 0 = SRAM, 1 = byte-control SRAM, 2 = burst ROM and 3 = other. For types 0 to 2, chip select is low with both strobes high for exactly 1 + setup cycles before the strobe becomes active. Setup may be 0 to 7.
- R4: The strobe is active for exactly 1 + wait cycles. `rd_n` is the strobe when `req_write` = 0, and `we_n` is the strobe when `req_write` = 1. The two strobes are never low together, and each is low only while `cs_n` is low.
- R5: After the strobe ends, chip select stays low for exactly the strobe-hold cycles plus the inserted address-hold cycles. No strobe becomes active again during that time.
- R6: For types 0 to 2, the number of inserted address-hold cycles is set as follows:
  - It equals the address-hold field.
  - The exception is when the field is greater than 1 and strobe-hold is greater than 1. The number inserted is then the field minus 1.
- R7: When wait = 0 and strobe-hold = 0, no address-hold cycle is inserted, whatever value the address-hold field holds.
- R8: For type 3, both setup and address hold are ignored. Chip select leads the strobe by exactly 1 cycle, and after the strobe it stays low for exactly the strobe-hold cycles.
- R9: On a read, `rsp_rdata` holds the `mem_rdata` value sampled in the last strobe cycle by the time `done` is 1.
- R10: While `cs_n` is low, `mem_addr` equals the accepted address. On writes, `mem_wdata` equals the accepted write data. `done` is a one-cycle pulse that occurs with `cs_n` high, and `req_ready` returns to 1 on the following cycle.
- R11: A request presented while `req_ready` is 0 is ignored. It starts no access and does not change the address of the access in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Loads the four timing fields |
| cfg_setup | input | 3 | Setup cycle count |
| cfg_ahold | input | 3 | Address-hold cycle count |
| cfg_wait | input | WAIT_W | Wait cycles added to the strobe |
| cfg_shold | input | SHOLD_W | Strobe-hold cycle count |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_itype | input | 2 | Interface type (0 to 3) |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Idle; a request is taken on this cycle |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Address bus |
| mem_wdata | output | DW | Write data bus |
| mem_rdata | input | DW | Read data bus |
| rsp_rdata | output | DW | Captured read data |
| done | output | 1 | Access complete pulse |

## Verification
The hardest case to reach is the reduced address hold. It only appears when the address-hold field and the strobe-hold count are both above one. The stimulus therefore programs several combinations around that threshold, including a field of exactly 1, and also includes the wait = 0, strobe-hold = 0 case that suppresses address hold entirely.

The reset defaults are visible only on the first access before any configuration write, so the bench issues that access first.

To exercise the ignored-request rule, the bench raises a second request with a different address in the middle of a long access. The monitor then confirms that the bus address never changes and that no extra chip-select window appears.

// File: rtl/sram_seq_pkg.sv
// Package: shared types for the SRAM bus cycle sequencer.
// Assumes: interface type codes are fixed as listed; phase order is fixed.
package sram_seq_pkg;

    typedef enum logic [1:0] {
        IF_SRAM   = 2'd0,
        IF_BCSRAM = 2'd1,
        IF_BROM   = 2'd2,
        IF_OTHER  = 2'd3
    } itype_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CSON   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_SHOLD  = 3'd4,
        PH_AHOLD  = 3'd5,
        PH_CSOFF  = 3'd6
    } phase_t;

    localparam int TFIELD_W = 3;

endpackage

// File: rtl/sram_seq_cfg.sv
// Module: timing field register.
// Holds setup, address-hold, wait and strobe-hold values.
// Assumes: writes happen while the sequencer is idle; resets to setup=7, hold=7.
module sram_seq_cfg
    import sram_seq_pkg::*;
#(
    parameter int WAIT_W  = 4,
    parameter int SHOLD_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [TFIELD_W-1:0] wr_setup,
    input  logic [TFIELD_W-1:0] wr_ahold,
    input  logic [WAIT_W-1:0]   wr_wait,
    input  logic [SHOLD_W-1:0]  wr_shold,
    output logic [TFIELD_W-1:0] q_setup,
    output logic [TFIELD_W-1:0] q_ahold,
    output logic [WAIT_W-1:0]   q_wait,
    output logic [SHOLD_W-1:0]  q_shold
);

    // Load the four timing fields; reset to the maximum setup and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_setup <= '1;
            q_ahold <= '1;
            q_wait  <= '0;
            q_shold <= '0;
        end else if (wr_en) begin
            q_setup <= wr_setup;
            q_ahold <= wr_ahold;
            q_wait  <= wr_wait;
            q_shold <= wr_shold;
        end
    end

endmodule

// File: rtl/sram_seq_calc.sv
// Module: effective cycle-count calculator.
// Turns the raw timing fields and interface type into the setup and
// address-hold counts actually inserted.
// Assumes: purely combinational; sampled by the phase engine on accept.
module sram_seq_calc
    import sram_seq_pkg::*;
#(
    parameter int WAIT_W  = 4,
    parameter int SHOLD_W = 3
) (
    input  logic [1:0]          itype,
    input  logic [TFIELD_W-1:0] f_setup,
    input  logic [TFIELD_W-1:0] f_ahold,
    input  logic [WAIT_W-1:0]   f_wait,
    input  logic [SHOLD_W-1:0]  f_shold,
    output logic [TFIELD_W-1:0] eff_setup,
    output logic [TFIELD_W-1:0] eff_ahold
);

    logic mem_style;
    logic no_hold_case;
    logic trim_case;

    // Classify the request: memory-style type, zero-wait/zero-hold, trim rule.
    always_comb begin
        mem_style    = (itype != IF_OTHER);
        no_hold_case = (f_wait == '0) && (f_shold == '0);
        trim_case    = (f_ahold > 3'd1) && (f_shold > SHOLD_W'(1));
    end

    // Select the inserted counts from the classification.
    always_comb begin
        eff_setup = mem_style ? f_setup : '0;
        if (!mem_style || no_hold_case) begin
            eff_ahold = '0;
        end else if (trim_case) begin
            eff_ahold = f_ahold - 3'd1;
        end else begin
            eff_ahold = f_ahold;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
// Module: phase engine.
// Steps through chip-select-on, setup, strobe, strobe-hold,
// address-hold and chip-select-off, skipping zero-length phases.
// Assumes: counts are latched when start is high in the idle phase.
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int WAIT_W  = 4,
    parameter int SHOLD_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [TFIELD_W-1:0] n_setup,
    input  logic [TFIELD_W-1:0] n_ahold,
    input  logic [WAIT_W-1:0]   n_wait,
    input  logic [SHOLD_W-1:0]  n_shold,
    output phase_t              phase,
    output logic                last_strobe
);

    localparam int CNT_W0 = (WAIT_W > SHOLD_W) ? WAIT_W : SHOLD_W;
    localparam int CNT_W  = (CNT_W0 > TFIELD_W) ? CNT_W0 : TFIELD_W;

    logic [TFIELD_W-1:0] su_q, ah_q;
    logic [WAIT_W-1:0]   wt_q;
    logic [SHOLD_W-1:0]  sh_q;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    phase_t              phase_d;

    // Flag the final strobe cycle for read-data capture.
    always_comb begin
        last_strobe = (phase == PH_STROBE) && (cnt_q == '0);
    end

    // Decide the next phase and counter load.
    always_comb begin
        phase_d = phase;
        cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        case (phase)
            PH_IDLE: begin
                if (start) phase_d = PH_CSON;
            end
            PH_CSON: begin
                if (su_q != '0) begin
                    phase_d = PH_SETUP;
                    cnt_d   = CNT_W'(su_q) - 1'b1;
                end else begin
                    phase_d = PH_STROBE;
                    cnt_d   = CNT_W'(wt_q);
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    phase_d = PH_STROBE;
                    cnt_d   = CNT_W'(wt_q);
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    if (sh_q != '0) begin
                        phase_d = PH_SHOLD;
                        cnt_d   = CNT_W'(sh_q) - 1'b1;
                    end else if (ah_q != '0) begin
                        phase_d = PH_AHOLD;
                        cnt_d   = CNT_W'(ah_q) - 1'b1;
                    end else begin
                        phase_d = PH_CSOFF;
                    end
                end
            end
            PH_SHOLD: begin
                if (cnt_q == '0) begin
                    if (ah_q != '0) begin
                        phase_d = PH_AHOLD;
                        cnt_d   = CNT_W'(ah_q) - 1'b1;
                    end else begin
                        phase_d = PH_CSOFF;
                    end
                end
            end
            PH_AHOLD: begin
                if (cnt_q == '0) phase_d = PH_CSOFF;
            end
            PH_CSOFF: phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Advance the phase register and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            phase <= phase_d;
            cnt_q <= cnt_d;
        end
    end

    // Latch the per-access counts when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            su_q <= '0;
            ah_q <= '0;
            wt_q <= '0;
            sh_q <= '0;
        end else if (start && (phase == PH_IDLE)) begin
            su_q <= n_setup;
            ah_q <= n_ahold;
            wt_q <= n_wait;
            sh_q <= n_shold;
        end
    end

endmodule

// File: rtl/sram_seq.sv
// Module: SRAM bus cycle timing sequencer (top).
// Takes one request at a time and drives chip select, read and write
// strobes, address and data, and returns read data with a done pulse.
// Assumes: requests are taken only while req_ready is high.
// Outputs are decoded from the registered phase.
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int WAIT_W  = 4,
    parameter int SHOLD_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_setup,
    input  logic [2:0]          cfg_ahold,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic [SHOLD_W-1:0]  cfg_shold,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_itype,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                req_ready,
    output logic                cs_n,
    output logic                rd_n,
    output logic                we_n,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    output logic [DW-1:0]       rsp_rdata,
    output logic                done
);

    logic [TFIELD_W-1:0] r_setup, r_ahold, e_setup, e_ahold;
    logic [WAIT_W-1:0]   r_wait;
    logic [SHOLD_W-1:0]  r_shold;
    phase_t              phase;
    logic                last_strobe;
    logic                take;
    logic                wr_q;

    sram_seq_cfg #(.WAIT_W(WAIT_W), .SHOLD_W(SHOLD_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_setup (cfg_setup),
        .wr_ahold (cfg_ahold),
        .wr_wait  (cfg_wait),
        .wr_shold (cfg_shold),
        .q_setup  (r_setup),
        .q_ahold  (r_ahold),
        .q_wait   (r_wait),
        .q_shold  (r_shold)
    );

    sram_seq_calc #(.WAIT_W(WAIT_W), .SHOLD_W(SHOLD_W)) u_calc (
        .itype     (req_itype),
        .f_setup   (r_setup),
        .f_ahold   (r_ahold),
        .f_wait    (r_wait),
        .f_shold   (r_shold),
        .eff_setup (e_setup),
        .eff_ahold (e_ahold)
    );

    sram_seq_fsm #(.WAIT_W(WAIT_W), .SHOLD_W(SHOLD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (take),
        .n_setup     (e_setup),
        .n_ahold     (e_ahold),
        .n_wait      (r_wait),
        .n_shold     (r_shold),
        .phase       (phase),
        .last_strobe (last_strobe)
    );

    // Accept a request only in the idle phase.
    always_comb begin
        req_ready = rst_n && (phase == PH_IDLE);
        take      = req_valid && req_ready;
    end

    // Decode the active-low bus controls from the phase; quiet in reset.
    always_comb begin
        cs_n = !rst_n || (phase == PH_IDLE) || (phase == PH_CSOFF);
        rd_n = !(rst_n && (phase == PH_STROBE) && !wr_q);
        we_n = !(rst_n && (phase == PH_STROBE) && wr_q);
        done = rst_n && (phase == PH_CSOFF);
    end

    // Register address, data and direction when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            wr_q      <= 1'b0;
        end else if (take) begin
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
            wr_q      <= req_write;
        end
    end

    // Capture read data at the end of the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (last_strobe && !wr_q) begin
            rsp_rdata <= mem_rdata;
        end
    end

endmodule

// File: rtl/sram_seq_chk.sv
// Module: assertion checker for the sequencer, attached by bind.
// Watches only the top-level ports of sram_seq.
module sram_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          we_n,
    input logic          done,
    input logic          req_ready,
    input logic [AW-1:0] mem_addr
);

    logic [3:0] lead_cnt;
    logic       strobed;

    // Track cycles before the strobe and whether the strobe has ended.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            lead_cnt <= '0;
            strobed  <= 1'b0;
        end else if (!rd_n || !we_n) begin
            strobed  <= 1'b1;
        end else if (!strobed && lead_cnt != 4'hF) begin
            lead_cnt <= lead_cnt + 4'd1;
        end
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (cs_n && rd_n && we_n); // R1
        end
    end

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !we_n)); // R4
    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !we_n) |-> !cs_n); // R4
    AST_SETUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !strobed) |-> (lead_cnt <= 4'd8)); // R3
    AST_NO_RESTROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && strobed && rd_n && we_n) |=> (cs_n || (rd_n && we_n))); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(mem_addr)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n ##1 (!done && req_ready)); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready); // R11

endmodule

bind sram_seq sram_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .we_n      (we_n),
    .done      (done),
    .req_ready (req_ready),
    .mem_addr  (mem_addr)
);

// File: tb/sim_sram_seq.sv
`timescale 1ns/1ps
// Bench: scoreboard for sram_seq. The driver pushes the expected timing
// of each access; a monitor measures the bus window and compares.
module sim_sram_seq;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WAIT_W = 4;
    localparam int SHOLD_W = 3;
    localparam logic [DW-1:0] RD_MASK = 16'h5A3C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_setup = '0, cfg_ahold = '0;
    logic [WAIT_W-1:0] cfg_wait = '0;
    logic [SHOLD_W-1:0] cfg_shold = '0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]        req_itype = '0;
    logic [AW-1:0]     req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              req_ready, cs_n, rd_n, we_n, done;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata, mem_rdata, rsp_rdata;

    int checks = 0;
    int errors = 0;

    // Shadow of the timing register, written from the requirements (R2 defaults).
    int sh_setup = 7, sh_ahold = 7, sh_wait = 0, sh_shold = 0;

    typedef struct {
        bit          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        int          lead, stb, tail;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    assign mem_rdata = mem_addr ^ RD_MASK;

    sram_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W), .SHOLD_W(SHOLD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
        .cfg_ahold(cfg_ahold), .cfg_wait(cfg_wait), .cfg_shold(cfg_shold),
        .req_valid(req_valid), .req_write(req_write), .req_itype(req_itype),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_rdata(rsp_rdata),
        .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int su, input int ah, input int wt, input int sh);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_setup = 3'(su);
        cfg_ahold = 3'(ah);
        cfg_wait = WAIT_W'(wt);
        cfg_shold = SHOLD_W'(sh);
        @(negedge clk);
        cfg_we = 1'b0;
        sh_setup = su; sh_ahold = ah; sh_wait = wt; sh_shold = sh;
    endtask

    // Driver: compute the expected window from R3..R8 and issue the request.
    task automatic access(input bit wr, input int ity, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit spam);
        item_t it;
        int ins_ah;
        bit mem_style;
        mem_style = (ity != 3);
        if (!mem_style) ins_ah = 0;                                  // R8
        else if (sh_wait == 0 && sh_shold == 0) ins_ah = 0;          // R7
        else if (sh_ahold > 1 && sh_shold > 1) ins_ah = sh_ahold - 1; // R6
        else ins_ah = sh_ahold;
        it.wr = wr; it.addr = a; it.wdata = d;
        it.lead = 1 + (mem_style ? sh_setup : 0);
        it.stb = 1 + sh_wait;
        it.tail = sh_shold + ins_ah;
        q.push_back(it);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_itype = 2'(ity);
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (spam) begin
            // R11: a request while busy must be ignored.
            @(negedge clk);
            req_valid = 1'b1; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after done", int'(req_ready), 1);
    endtask

    // Monitor: measure each chip-select window and compare with the queue.
    item_t cur;
    bit    active = 1'b0, seen = 1'b0, bad_strobe = 1'b0, bad_bus = 1'b0;
    int    lead = 0, stb = 0, tail = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n) begin
                if (!active) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R11 unexpected access", 1, 0);
                    end else begin
                        cur = q.pop_front();
                    end
                    active = 1'b1; seen = 1'b0; lead = 0; stb = 0; tail = 0;
                    bad_strobe = 1'b0; bad_bus = 1'b0;
                end
                if (mem_addr != cur.addr) bad_bus = 1'b1;
                if (cur.wr && mem_wdata != cur.wdata) bad_bus = 1'b1;
                if (!rd_n || !we_n) begin
                    stb++;
                    if (seen && tail != 0) bad_strobe = 1'b1;
                    seen = 1'b1;
                    if (cur.wr ? !rd_n : !we_n) bad_strobe = 1'b1;
                end else if (!seen) begin
                    lead++;
                end else begin
                    tail++;
                end
            end
            if (done && active) begin
                active = 1'b0;
                chk(cs_n == 1'b1, "R10 cs high at done", int'(cs_n), 1);
                chk(lead == cur.lead, "R3/R8 lead cycles", lead, cur.lead);
                chk(stb == cur.stb, "R4 strobe cycles", stb, cur.stb);
                chk(!bad_strobe, "R4 strobe direction", int'(bad_strobe), 0);
                chk(tail == cur.tail, "R5/R6/R7 tail cycles", tail, cur.tail);
                chk(!bad_bus, "R10 address/data stable", int'(bad_bus), 0);
                if (!cur.wr)
                    chk(rsp_rdata == (cur.addr ^ RD_MASK), "R9 read data",
                        int'(rsp_rdata), int'(cur.addr ^ RD_MASK));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && rd_n && we_n, "R1 quiet in reset", int'({cs_n, rd_n, we_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        // R2 defaults: setup 7, hold 7, wait 0, strobe-hold 0 -> no hold (R7)
        access(1'b0, 0, 16'h1234, 16'h0, 1'b0);
        set_cfg(2, 3, 1, 0);
        access(1'b0, 0, 16'h2001, 16'h0, 1'b0);      // R6 field kept
        set_cfg(2, 3, 1, 2);
        access(1'b1, 0, 16'h3002, 16'hBEEF, 1'b0);   // R6 trimmed by one
        set_cfg(1, 1, 0, 2);
        access(1'b0, 1, 16'h4003, 16'h0, 1'b0);      // R6 field of one kept
        set_cfg(3, 4, 2, 1);
        access(1'b0, 1, 16'h5004, 16'h0, 1'b0);      // R5 strobe-hold 1
        set_cfg(2, 5, 0, 0);
        access(1'b1, 2, 16'h6005, 16'hCAFE, 1'b0);   // R7 no hold
        set_cfg(2, 5, 2, 0);
        access(1'b0, 2, 16'h7006, 16'h0, 1'b0);      // R7 wait nonzero: hold kept
        set_cfg(6, 6, 1, 2);
        access(1'b0, 3, 16'h8007, 16'h0, 1'b0);      // R8 other type
        access(1'b1, 3, 16'h8107, 16'h1357, 1'b0);   // R8 write
        set_cfg(7, 7, 3, 3);
        access(1'b0, 0, 16'h9008, 16'h0, 1'b1);      // R11 busy request
        set_cfg(0, 0, 3, 0);
        access(1'b1, 0, 16'hA009, 16'h2468, 1'b0);   // R3 zero setup
        repeat (4) @(negedge clk);
        chk(q.size() == 0 && cs_n, "R11 no extra access", q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule